// File: doc/BRIEF.md
# Sensor-Driven Two-Way Intersection Light Controller

This block sequences the signal heads at a junction of two roads, called the main road and the cross road here. Each road has a presence detector. A road keeps its green for as long as its detector sees traffic. When the detector goes quiet, that road shows amber for exactly one clock period, and then the other road gets green. One clock period is one phase. There are no timers. The lights depend only on the registered phase, so the outputs never follow a detector input within the same cycle.

The phase is held in a two-bit register: main green = 00, main amber = 01, cross green = 10, cross amber = 11. The control module computes the next phase and gives the datapath a small struct of strobes. The datapath holds the phase register and decodes it into the two light codes. Each light code is 2 bits: green = 00, amber = 01, red = 10. The value 11 is never driven. Reset is synchronous and active high. The detector inputs are assumed to be already synchronous to the clock.

Top module: `xing_light_ctrl`

## Requirements
- R1: A synchronous, active-high reset puts the phase to main green: mainLight = 00 (green) and crossLight = 10 (red) after the reset edge.
- R2: In main green, a clock edge with mainSense = 1 keeps main green. A clock edge with mainSense = 0 moves to main amber: mainLight = 01, crossLight = 10.
- R3: Main amber always moves to cross green on the next edge (mainLight = 10, crossLight = 00), whatever the detector inputs are.
- R4: In cross green, a clock edge with crossSense = 1 keeps cross green. A clock edge with crossSense = 0 moves to cross amber: mainLight = 10, crossLight = 01.
- R5: Cross amber always moves to main green on the next edge, whatever the detector inputs are.
- R6: The detector of the road that currently shows red has no effect on the next phase.
- R7: The two lights are never green or amber at the same time, and neither light is ever 11.
- R8: A light that changes from green to red always passes through exactly one cycle of amber.
- R9: The lights are a function of the current phase only. A change on a detector input between clock edges does not change an output until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one phase |
| rst | input | 1 | Synchronous reset, active high |
| mainSense | input | 1 | Main road presence detector |
| crossSense | input | 1 | Cross road presence detector |
| mainLight | output | 2 | Main road light code (00 green, 01 amber, 10 red) |
| crossLight | output | 2 | Cross road light code (00 green, 01 amber, 10 red) |

## Verification
A wrong phase register shows at the lights right after the clock edge that loads it, because the decode has no further register. An illegal pair of lights, such as both green or a missing amber, therefore shows up in the sample after the faulty transition. The bench follows every detector combination from every phase with its own model of the phase. It compares both lights after every edge, so a wrong transition is seen within one cycle. It also changes the detectors in the middle of a cycle, to show that they do not reach the outputs combinationally.

// File: rtl/xing_light_pkg.sv
package xing_light_pkg;
  localparam int PHASE_W = 2;
  localparam int LIGHT_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_MAIN_GO   = 2'b00,
    PH_MAIN_WARN = 2'b01,
    PH_CROSS_GO  = 2'b10,
    PH_CROSS_WARN = 2'b11
  } phase_e;

  typedef enum logic [LIGHT_W-1:0] {
    LT_GREEN = 2'b00,
    LT_AMBER = 2'b01,
    LT_RED   = 2'b10
  } light_e;

  typedef struct packed {
    logic   loadInit;
    logic   advance;
    phase_e nextPhase;
  } ctrl_strobe_t;
endpackage

// File: rtl/xing_light_ctrl_fsm.sv
module xing_light_ctrl_fsm
  import xing_light_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         mainSense,
  input  logic         crossSense,
  input  phase_e       curPhase,
  output ctrl_strobe_t strobe
);
  phase_e nxt;

  always_comb begin
    nxt = curPhase;
    unique case (curPhase)
      PH_MAIN_GO:    nxt = mainSense  ? PH_MAIN_GO  : PH_MAIN_WARN;
      PH_MAIN_WARN:  nxt = PH_CROSS_GO;
      PH_CROSS_GO:   nxt = crossSense ? PH_CROSS_GO : PH_CROSS_WARN;
      PH_CROSS_WARN: nxt = PH_MAIN_GO;
      default:       nxt = PH_MAIN_GO;
    endcase
  end

  always_comb begin
    strobe.loadInit  = rst;
    strobe.advance   = !rst && (nxt != curPhase);
    strobe.nextPhase = nxt;
  end

  // The high bit of the next phase is the XOR of the two current bits.
  AST_HIGH_BIT_XOR: assert property (@(posedge clk) disable iff (rst)
    strobe.nextPhase[1] == (curPhase[1] ^ curPhase[0])) // R3
    else $error("next-phase high bit wrong");
  AST_AMBER_LEAVES: assert property (@(posedge clk) disable iff (rst)
    curPhase[0] |-> strobe.advance) // R5
    else $error("amber phase did not advance");
endmodule

// File: rtl/xing_light_datapath.sv
module xing_light_datapath
  import xing_light_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  ctrl_strobe_t strobe,
  output phase_e       curPhase,
  output logic [LIGHT_W-1:0] mainLight,
  output logic [LIGHT_W-1:0] crossLight
);
  phase_e phaseQ;
  logic   warmQ;

  always_ff @(posedge clk) begin
    if (strobe.loadInit) begin
      phaseQ <= PH_MAIN_GO;
      warmQ  <= 1'b0;
    end else begin
      warmQ <= 1'b1;
      if (strobe.advance) phaseQ <= strobe.nextPhase;
    end
  end

  assign curPhase = phaseQ;

  always_comb begin
    if (phaseQ[1]) begin
      mainLight  = LT_RED;
      crossLight = phaseQ[0] ? LT_AMBER : LT_GREEN;
    end else begin
      crossLight = LT_RED;
      mainLight  = phaseQ[0] ? LT_AMBER : LT_GREEN;
    end
  end

  AST_ONE_ROAD_MOVES: assert property (@(posedge clk) disable iff (rst || !warmQ)
    (mainLight == LT_RED) || (crossLight == LT_RED)) // R7
    else $error("both roads released");
  AST_NO_CODE_11: assert property (@(posedge clk) disable iff (rst || !warmQ)
    (mainLight != 2'b11) && (crossLight != 2'b11)) // R7
    else $error("illegal light code");
  AST_MAIN_AMBER_FIRST: assert property (@(posedge clk) disable iff (rst || !warmQ)
    (mainLight == LT_GREEN) |=> (mainLight != LT_RED)) // R8
    else $error("main skipped amber");
  AST_CROSS_AMBER_FIRST: assert property (@(posedge clk) disable iff (rst || !warmQ)
    (crossLight == LT_GREEN) |=> (crossLight != LT_RED)) // R8
    else $error("cross skipped amber");
  AST_AMBER_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst || !warmQ)
    (mainLight == LT_AMBER) |=> (mainLight == LT_RED)) // R3
    else $error("main amber held");
endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
  import xing_light_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mainSense,
  input  logic       crossSense,
  output logic [1:0] mainLight,
  output logic [1:0] crossLight
);
  ctrl_strobe_t strobe;
  phase_e       curPhase;

  xing_light_ctrl_fsm u_fsm (
    .clk(clk), .rst(rst), .mainSense(mainSense), .crossSense(crossSense),
    .curPhase(curPhase), .strobe(strobe)
  );

  xing_light_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .curPhase(curPhase),
    .mainLight(mainLight), .crossLight(crossLight)
  );
endmodule

// File: tb/tb_xing_light_ctrl.sv
module tb_xing_light_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, mainSense = 0, crossSense = 0;
  logic [1:0] mainLight, crossLight;
  int checks = 0, failures = 0;
  int model = 0;
  bit done = 0;

  xing_light_ctrl dut (.clk(clk), .rst(rst), .mainSense(mainSense),
    .crossSense(crossSense), .mainLight(mainLight), .crossLight(crossLight));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] expMain(int p);
    return (p == 0) ? 2'b00 : (p == 1) ? 2'b01 : 2'b10;
  endfunction
  function automatic logic [1:0] expCross(int p);
    return (p == 2) ? 2'b00 : (p == 3) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(string req);
    checks++;
    if (mainLight !== expMain(model) || crossLight !== expCross(model)) begin
      failures++;
      $display("FAIL %s main=%b cross=%b expected main=%b cross=%b",
        req, mainLight, crossLight, expMain(model), expCross(model));
    end
    checks++;
    if (mainLight != 2'b10 && crossLight != 2'b10) begin
      failures++;
      $display("FAIL R7 main=%b cross=%b expected one red", mainLight, crossLight);
    end
  endtask

  // One edge with given detectors; model updated arithmetically.
  task automatic step(logic a, logic b, string req);
    int prevMain;
    prevMain = model;
    mainSense = a; crossSense = b;
    @(posedge clk);
    case (model)
      0: model = a ? 0 : 1;
      1: model = 2;
      2: model = b ? 2 : 3;
      default: model = 0;
    endcase
    #1;
    check(req);
    if (prevMain == 0 && expMain(model) == 2'b10) begin
      checks++; failures++;
      $display("FAIL R8 main=%b expected 01", mainLight);
    end
  endtask

  task automatic goTo(int p);
    while (model != p) step(model == 0 ? 0 : 1, model == 2 ? 0 : 1, "R2");
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog main=%b cross=%b expected finish", mainLight, crossLight);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(posedge clk); @(posedge clk); #1;
    model = 0; check("R1");
    rst = 0;
    // Exhaustive sweep: every phase, every detector combination.
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 4; v++) begin
        goTo(p);
        step(v[1], v[0], p == 0 ? "R2" : p == 1 ? "R3" : p == 2 ? "R4" : "R5");
      end
    end
    // R6: detector of red road ignored while other road held green.
    goTo(0);
    for (int i = 0; i < 4; i++) step(1, i[0], "R6");
    goTo(2);
    for (int i = 0; i < 4; i++) step(i[0], 1, "R6");
    // R9: mid-cycle toggles leave outputs steady.
    goTo(0);
    mainSense = 1; @(posedge clk); #2;
    mainSense = 0; #2; check("R9");
    mainSense = 1; #2; check("R9");
    // Reset from a non-initial phase.
    goTo(3);
    rst = 1; @(posedge clk); #1; model = 0; check("R1");
    rst = 0;
    // Long random-ish walk.
    for (int i = 0; i < 200; i++) step(((i*7)%5) > 1, ((i*3)%4) > 0, "R8");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule